// File: doc/BRIEF.md
# Bit-Serial Password Verifier with Attempts Counter

This block sits beside a serially addressed secure bit memory. An external address counter walks the bit array one position per step. On each step the block sees the current address, the stored bit at that address and strobes from the host. Inside a password field, a compare strobe carries one host bit. The block matches these bits one at a time against the stored bits and decides whether three access flags may be raised: a security-validated flag (SV) and two zone-erase flags (E1, E2).

Matching the security code is not enough on its own to set SV. The host must then find a still-set bit in the eight active positions of an attempts counter, write that bit to 0 and erase the same bit. Only a correct code followed by this write/erase pair sets SV. When it does, the block requests that the whole 16-bit counter be refilled with ones. A wrong code leaves the written zero in place. Eight written zeros lock the card until power-on reset, and in practice for good, since the counter can no longer be refilled.

Erase key 2 works the same way when the erase-counter fuse is set. It then needs a write/erase pair on a still-set bit of a 128-bit erase counter, and that counter is never refilled. The block also drives a status bit that reports the outcome of each program step.

Top module: `serial_pwd_verifier`

## Requirements
- R1: After power-on reset (`rst` high), `sv`, `e1`, `e2`, `locked` and `att_wipe` are 0 and `status_bit` is 1.
- R2: `sv` rises only after three steps, in this order:
  - compare strobes at every address 80 to 95, consecutively, in which the host bit (address 80+i holding code bit i) equals the stored bit;
  - a write strobe at an address in 96 to 103 whose stored bit is 1;
  - an erase strobe at that same address.
  
  `sv` reads 1 in the cycle after the erase strobe.
- R3: `status_bit` goes to 0 in the cycle after a qualifying write strobe. After the closing erase strobe it is 0 on success and 1 on failure.
- R4: A successful security-code verification pulses `att_wipe` for exactly one cycle, in the cycle after the erase strobe. This pulse is the request to set addresses 96 to 111 to 1. A failed verification never pulses it.
- R5: `locked` rises once the most recent stored values seen at all eight addresses 96 to 103 are 0. It then stays 1 until power-on reset. While `locked` is 1, `sv` cannot rise.
- R6: Once set, `sv` stays 1 until power-on reset. The address returning to 0 does not clear it.
- R7: `e1` rises after a full consecutive matching compare of the 48-bit erase key 1 at addresses 688 to 735. Both `e1` and `e2` read 0 in the cycle after any cycle in which `addr` is 0.
- R8: With `ec_fuse` at 0, `e2` rises after a full consecutive matching compare of the 32-bit erase key 2 at addresses 1248 to 1279.
- R9: With `ec_fuse` at 1, a key-2 match alone does not raise `e2`. `e2` rises only after a following write and erase, at the same address, on a stored-1 bit in 1280 to 1407. That erase never pulses `att_wipe`.
- R10: A single mismatching bit at any position of a field (first, middle or last) prevents that field's flag.
- R11: A compare run broken inside the field sets no flag. A break is a step in which the address advances without a compare strobe, or in which the address leaves the field.
- R12: A write strobe on an attempts-counter bit whose stored value is already 0 is ignored. `status_bit` is unchanged and a later erase there completes no verification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| addr | input | 11 | Current bit address from the external counter |
| cmp_stb | input | 1 | Compare strobe: `host_bit` is a password bit for `addr` |
| host_bit | input | 1 | Host data bit for the compare |
| mem_bit | input | 1 | Stored memory bit at `addr` (value before any program in this cycle) |
| wr_done | input | 1 | Write (to 0) completed at `addr` |
| er_done | input | 1 | Erase (to 1) completed at `addr` |
| ec_fuse | input | 1 | Erase-counter enable fuse, 1 = zone-2 erases counted |
| sv | output | 1 | Security-validated flag |
| e1 | output | 1 | Zone-1 erase flag |
| e2 | output | 1 | Zone-2 erase flag |
| locked | output | 1 | Attempts exhausted |
| status_bit | output | 1 | Status returned after program steps |
| att_wipe | output | 1 | One-cycle request to set the 16 attempts-counter bits to 1 |

## Verification
The situation hardest to reach from the ports is the lock. It needs eight complete failed tries: a wrong code, then a walk to a fresh still-set counter bit, then a write/erase on it. The bench keeps a bit-memory model that turns written bits to 0. On the eighth try it walks across all eight zeros, which raises `locked`. It then presents the correct code and shows that no completing write is possible. The erase-counter path is reached by setting the fuse and following a clean key-2 compare with a write/erase in the counter window. The bench checks that this raises `e2` without a wipe request.

// File: rtl/pwv_pkg.sv
package pwv_pkg;

    parameter int ADDR_W = 11;
    typedef logic [ADDR_W-1:0] addr_t;

    // Field placement; the matcher and ritual windows depend on these.
    localparam int SC_BASE    = 80;
    localparam int SC_BITS    = 16;
    localparam int ATT_BASE   = 96;
    localparam int ATT_ACTIVE = 8;
    localparam int ATT_BITS   = 16;
    localparam int EZ1_BASE   = 688;
    localparam int EZ1_BITS   = 48;
    localparam int EZ2_BASE   = 1248;
    localparam int EZ2_BITS   = 32;
    localparam int EC_BASE    = 1280;
    localparam int EC_BITS    = 128;

    localparam int NUM_FLD = 3;

    typedef enum logic [1:0] {
        FLD_CODE = 2'd0,
        FLD_KEY1 = 2'd1,
        FLD_KEY2 = 2'd2
    } fld_e;

    typedef enum logic {
        RIT_IDLE    = 1'b0,
        RIT_WRITTEN = 1'b1
    } rit_e;

    typedef struct packed {
        logic wrote;
        logic ok;
        logic bad;
    } rit_evt_t;

    function automatic logic in_win(addr_t a, int lo, int hi);
        return (int'(a) >= lo) && (int'(a) <= hi);
    endfunction

endpackage

// File: rtl/pwv_field_match.sv
module pwv_field_match
    import pwv_pkg::*;
#(
    parameter int BASE = 80,
    parameter int BITS = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  addr_t addr,
    input  logic  cmp_stb,
    input  logic  host_bit,
    input  logic  mem_bit,
    output logic  pass
);

    localparam int LAST = BASE + BITS - 1;

    logic  run_q;
    logic  match_q;
    addr_t prev_q;

    logic eq;
    logic at_base;
    logic at_last;
    logic in_fld;
    logic follow;

    always_comb begin
        eq      = (host_bit == mem_bit);
        at_base = (addr == addr_t'(BASE));
        at_last = (addr == addr_t'(LAST));
        in_fld  = in_win(addr, BASE, LAST);
        follow  = run_q && (addr == prev_q + addr_t'(1));
        pass    = cmp_stb && at_last && eq && (at_base || (follow && match_q));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            match_q <= 1'b0;
            prev_q  <= '0;
        end else if (cmp_stb && at_base) begin
            run_q   <= !at_last;
            match_q <= eq;
            prev_q  <= addr;
        end else if (cmp_stb && in_fld) begin
            if (follow) begin
                match_q <= match_q && eq;
                prev_q  <= addr;
                run_q   <= !at_last;
            end else begin
                run_q   <= 1'b0;
                match_q <= 1'b0;
            end
        end else if (!in_fld) begin
            run_q   <= 1'b0;
            match_q <= 1'b0;
        end
    end

    AST_RUN_ENDS_AFTER_PASS: assert property (@(posedge clk) disable iff (rst)
        pass |=> !run_q); // R11

    AST_RUN_DROPS_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        (!in_fld && !cmp_stb) |=> !run_q); // R11

endmodule

// File: rtl/pwv_ritual.sv
module pwv_ritual
    import pwv_pkg::*;
#(
    parameter int LO = 96,
    parameter int HI = 103
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     armed,
    input  addr_t    addr,
    input  logic     mem_bit,
    input  logic     wr_done,
    input  logic     er_done,
    output rit_evt_t evt
);

    rit_e  st_q;
    addr_t wa_q;
    logic  in_w;
    logic  fin;

    always_comb begin
        in_w      = in_win(addr, LO, HI);
        evt.wrote = en && wr_done && in_w && mem_bit;
        fin       = en && er_done && (st_q == RIT_WRITTEN) && (addr == wa_q);
        evt.ok    = fin && armed;
        evt.bad   = fin && !armed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RIT_IDLE;
            wa_q <= '0;
        end else if (evt.wrote) begin
            st_q <= RIT_WRITTEN;
            wa_q <= addr;
        end else if (fin) begin
            st_q <= RIT_IDLE;
        end else if ((st_q == RIT_WRITTEN) && (addr != wa_q)) begin
            st_q <= RIT_IDLE;
        end
    end

    AST_RIT_NEEDS_SET_BIT: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == RIT_WRITTEN) |-> $past(wr_done && mem_bit)); // R12

    AST_RIT_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (evt.ok || evt.bad) |=> (st_q == RIT_IDLE)); // R2

endmodule

// File: rtl/pwv_lock_scan.sv
module pwv_lock_scan
    import pwv_pkg::*;
#(
    parameter int LO = 96,
    parameter int N  = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wipe,
    input  addr_t addr,
    input  logic  mem_bit,
    output logic  all_zero
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     seen_q;
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx      = IDX_W'(int'(addr) - LO);
        all_zero = (seen_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            seen_q <= '1;
        end else if (in_win(addr, LO, LO + N - 1)) begin
            seen_q[idx] <= mem_bit;
        end
    end

    AST_WIPE_REFILLS: assert property (@(posedge clk) disable iff (rst)
        wipe |=> !all_zero); // R5

endmodule

// File: rtl/serial_pwd_verifier.sv
module serial_pwd_verifier
    import pwv_pkg::*;
#(
    parameter int P_SC_BASE    = SC_BASE,
    parameter int P_SC_BITS    = SC_BITS,
    parameter int P_ATT_BASE   = ATT_BASE,
    parameter int P_ATT_ACTIVE = ATT_ACTIVE,
    parameter int P_EZ1_BASE   = EZ1_BASE,
    parameter int P_EZ1_BITS   = EZ1_BITS,
    parameter int P_EZ2_BASE   = EZ2_BASE,
    parameter int P_EZ2_BITS   = EZ2_BITS,
    parameter int P_EC_BASE    = EC_BASE,
    parameter int P_EC_BITS    = EC_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cmp_stb,
    input  logic              host_bit,
    input  logic              mem_bit,
    input  logic              wr_done,
    input  logic              er_done,
    input  logic              ec_fuse,
    output logic              sv,
    output logic              e1,
    output logic              e2,
    output logic              locked,
    output logic              status_bit,
    output logic              att_wipe
);

    localparam int ATT_LAST = P_ATT_BASE + P_ATT_ACTIVE - 1;
    localparam int EC_LAST  = P_EC_BASE + P_EC_BITS - 1;
    localparam int EZ1_LAST = P_EZ1_BASE + P_EZ1_BITS - 1;
    localparam int FLD_BASE [NUM_FLD] = '{P_SC_BASE, P_EZ1_BASE, P_EZ2_BASE};
    localparam int FLD_BITS [NUM_FLD] = '{P_SC_BITS, P_EZ1_BITS, P_EZ2_BITS};

    logic [NUM_FLD-1:0] pass_v;
    rit_evt_t           rs;
    rit_evt_t           re;
    logic               all_zero;

    logic sv_q, e1_q, e2_q, lock_q, stat_q, wipe_q;
    logic code_ok_q, key2_ok_q;

    logic code_start, key2_start, at_zero;

    generate
        for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
            pwv_field_match #(
                .BASE (FLD_BASE[g]),
                .BITS (FLD_BITS[g])
            ) u_match (
                .clk      (clk),
                .rst      (rst),
                .addr     (addr),
                .cmp_stb  (cmp_stb),
                .host_bit (host_bit),
                .mem_bit  (mem_bit),
                .pass     (pass_v[g])
            );
        end
    endgenerate

    pwv_ritual #(
        .LO (P_ATT_BASE),
        .HI (ATT_LAST)
    ) u_att_rit (
        .clk     (clk),
        .rst     (rst),
        .en      (1'b1),
        .armed   (code_ok_q),
        .addr    (addr),
        .mem_bit (mem_bit),
        .wr_done (wr_done),
        .er_done (er_done),
        .evt     (rs)
    );

    pwv_ritual #(
        .LO (P_EC_BASE),
        .HI (EC_LAST)
    ) u_ec_rit (
        .clk     (clk),
        .rst     (rst),
        .en      (ec_fuse),
        .armed   (key2_ok_q),
        .addr    (addr),
        .mem_bit (mem_bit),
        .wr_done (wr_done),
        .er_done (er_done),
        .evt     (re)
    );

    pwv_lock_scan #(
        .LO (P_ATT_BASE),
        .N  (P_ATT_ACTIVE)
    ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .wipe     (wipe_q),
        .addr     (addr),
        .mem_bit  (mem_bit),
        .all_zero (all_zero)
    );

    always_comb begin
        code_start = cmp_stb && (addr == addr_t'(P_SC_BASE));
        key2_start = cmp_stb && (addr == addr_t'(P_EZ2_BASE));
        at_zero    = (addr == '0);
    end

    // Pending "code matched" and "key 2 matched" state between compare and ritual
    always_ff @(posedge clk) begin
        if (rst) begin
            code_ok_q <= 1'b0;
            key2_ok_q <= 1'b0;
        end else begin
            if (pass_v[FLD_CODE])
                code_ok_q <= 1'b1;
            else if (code_start || rs.ok || rs.bad || !in_win(addr, P_SC_BASE, ATT_LAST))
                code_ok_q <= 1'b0;

            if (pass_v[FLD_KEY2] && ec_fuse)
                key2_ok_q <= 1'b1;
            else if (key2_start || re.ok || re.bad || !ec_fuse
                     || !in_win(addr, P_EZ2_BASE, EC_LAST))
                key2_ok_q <= 1'b0;
        end
    end

    // Access flags, lock and status
    always_ff @(posedge clk) begin
        if (rst) begin
            sv_q   <= 1'b0;
            e1_q   <= 1'b0;
            e2_q   <= 1'b0;
            lock_q <= 1'b0;
            stat_q <= 1'b1;
            wipe_q <= 1'b0;
        end else begin
            if (rs.ok && !lock_q)
                sv_q <= 1'b1;
            wipe_q <= rs.ok && !lock_q;

            if (at_zero)
                e1_q <= 1'b0;
            else if (pass_v[FLD_KEY1])
                e1_q <= 1'b1;

            if (at_zero)
                e2_q <= 1'b0;
            else if ((pass_v[FLD_KEY2] && !ec_fuse) || re.ok)
                e2_q <= 1'b1;

            if (all_zero)
                lock_q <= 1'b1;

            if (rs.wrote || re.wrote || rs.ok || re.ok)
                stat_q <= 1'b0;
            else if (rs.bad || re.bad)
                stat_q <= 1'b1;
        end
    end

    assign sv         = sv_q;
    assign e1         = e1_q;
    assign e2         = e2_q;
    assign locked     = lock_q;
    assign status_bit = stat_q;
    assign att_wipe   = wipe_q;

    AST_SV_HOLDS: assert property (@(posedge clk) disable iff (rst)
        sv_q |=> sv_q); // R6

    AST_ERASE_FLAGS_CLEAR_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        at_zero |=> (!e1_q && !e2_q)); // R7

    AST_LOCK_BLOCKS_SV: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !sv_q) |=> !sv_q); // R5

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q); // R5

    AST_STATUS_LOW_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rs.wrote || re.wrote) |=> !stat_q); // R3

    AST_SV_RISE_NEEDS_ERASE: assert property (@(posedge clk) disable iff (rst)
        $rose(sv_q) |-> $past(er_done && code_ok_q)); // R2

    AST_E1_RISE_ON_LAST_COMPARE: assert property (@(posedge clk) disable iff (rst)
        $rose(e1_q) |-> $past(cmp_stb && (addr == addr_t'(EZ1_LAST)))); // R7

    AST_E2_COUNTED_NEEDS_ERASE: assert property (@(posedge clk) disable iff (rst)
        ($rose(e2_q) && $past(ec_fuse)) |-> $past(er_done)); // R9

    AST_WIPE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        att_wipe |=> !att_wipe); // R4

endmodule

// File: tb/serial_pwd_verifier_tb_top.sv
`timescale 1ns/1ps
module serial_pwd_verifier_tb_top;
    import pwv_pkg::*;

    localparam logic [15:0] SC_VAL  = 16'hA5C3;
    localparam logic [47:0] EZ1_VAL = 48'h3C5A_F00F_9669;
    localparam logic [31:0] EZ2_VAL = 32'hC0DE_5AA5;
    localparam int MEM_N = 1568;
    localparam logic [7:0] NONE = 8'hFF;

    // Vector: {field[1:0], flip index[7:0], gap index[7:0], expected flag}
    localparam int NVEC = 7;
    localparam logic [18:0] VEC [NVEC] = '{
        {2'd1, NONE,  NONE,  1'b1},
        {2'd1, 8'd47, NONE,  1'b0},
        {2'd1, 8'd0,  NONE,  1'b0},
        {2'd2, NONE,  NONE,  1'b1},
        {2'd2, 8'd17, NONE,  1'b0},
        {2'd1, NONE,  8'd20, 1'b0},
        {2'd2, NONE,  8'd31, 1'b0}
    };

    logic clk = 1'b0;
    logic rst, cmp_stb, host_bit, mem_bit, wr_done, er_done, ec_fuse;
    logic [ADDR_W-1:0] addr;
    logic sv, e1, e2, locked, status_bit, att_wipe;
    logic mem [0:MEM_N-1];
    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    assign mem_bit = mem[addr];

    serial_pwd_verifier dut_i (
        .clk(clk), .rst(rst), .addr(addr), .cmp_stb(cmp_stb), .host_bit(host_bit),
        .mem_bit(mem_bit), .wr_done(wr_done), .er_done(er_done), .ec_fuse(ec_fuse),
        .sv(sv), .e1(e1), .e2(e2), .locked(locked), .status_bit(status_bit),
        .att_wipe(att_wipe)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cmp_stb = 1'b0;
        wr_done = 1'b0;
        er_done = 1'b0;
    endtask

    task automatic go(input int a);
        addr = ADDR_W'(a);
        cyc();
    endtask

    task automatic wr(input int a);
        addr = ADDR_W'(a);
        wr_done = 1'b1;
        cyc();
        mem[a] = 1'b0;
    endtask

    task automatic er(input int a);
        addr = ADDR_W'(a);
        er_done = 1'b1;
        cyc();
        if (att_wipe === 1'b1)
            for (int k = ATT_BASE; k < ATT_BASE + ATT_BITS; k++) mem[k] = 1'b1;
    endtask

    // Present a password field; flip inverts one bit, gap replaces one compare by a plain step
    task automatic present(input int fld, input logic [7:0] flip, input logic [7:0] gap);
        int base;
        int len;
        logic [63:0] val;
        base = (fld == 0) ? SC_BASE : (fld == 1) ? EZ1_BASE : EZ2_BASE;
        len  = (fld == 0) ? SC_BITS : (fld == 1) ? EZ1_BITS : EZ2_BITS;
        val  = (fld == 0) ? 64'(SC_VAL) : (fld == 1) ? 64'(EZ1_VAL) : 64'(EZ2_VAL);
        for (int i = 0; i < len; i++) begin
            addr = ADDR_W'(base + i);
            if (i == int'(gap)) begin
                cmp_stb = 1'b0;
            end else begin
                cmp_stb  = 1'b1;
                host_bit = val[i] ^ (i == int'(flip));
            end
            cyc();
        end
    endtask

    task automatic fail_try(input int k);
        go(0);
        present(0, 8'd0, NONE);
        for (int a = ATT_BASE; a <= ATT_BASE + k; a++) go(a);
        wr(ATT_BASE + k);
        er(ATT_BASE + k);
        chk("R3 failed try status", status_bit, 1'b1);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < MEM_N; k++) mem[k] = 1'b1;
        for (int i = 0; i < SC_BITS; i++)  mem[SC_BASE + i]  = SC_VAL[i];
        for (int i = 0; i < EZ1_BITS; i++) mem[EZ1_BASE + i] = EZ1_VAL[i];
        for (int i = 0; i < EZ2_BITS; i++) mem[EZ2_BASE + i] = EZ2_VAL[i];
        rst = 1'b1; addr = '0; cmp_stb = 1'b0; host_bit = 1'b0;
        wr_done = 1'b0; er_done = 1'b0; ec_fuse = 1'b0;
        @(negedge clk);
        repeat (3) cyc();
        rst = 1'b0;
        go(0);

        // R1 reset state
        chk("R1 sv", sv, 1'b0);
        chk("R1 e1", e1, 1'b0);
        chk("R1 e2", e2, 1'b0);
        chk("R1 locked", locked, 1'b0);
        chk("R1 status", status_bit, 1'b1);
        chk("R1 att_wipe", att_wipe, 1'b0);

        // Vector table: erase-key compares (R7, R8, R10, R11)
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            int fld;
            logic got;
            fld = int'(VEC[v][18:17]);
            go(0);
            present(fld, VEC[v][16:9], VEC[v][8:1]);
            got = (fld == 1) ? e1 : e2;
            if (VEC[v][8:1] != NONE)       tag = "R11 interrupted compare";
            else if (VEC[v][16:9] != NONE) tag = "R10 mismatching bit";
            else if (fld == 1)             tag = "R7 key1 match";
            else                           tag = "R8 key2 match";
            chk(tag, got, VEC[v][0]);
        end

        // R7 clear at address 0
        go(0);
        present(1, NONE, NONE);
        chk("R7 e1 set", e1, 1'b1);
        go(0);
        chk("R7 e1 cleared at addr 0", e1, 1'b0);

        // Wrong code plus ritual
        present(0, 8'd5, NONE);
        go(96);
        wr(96);
        chk("R3 status after write", status_bit, 1'b0);
        er(96);
        chk("R3 status after failed erase", status_bit, 1'b1);
        chk("R10 sv after wrong code", sv, 1'b0);
        chk("R4 no wipe on failure", att_wipe, 1'b0);

        // R12 write on a zero bit is ignored
        wr(96);
        chk("R12 status unchanged", status_bit, 1'b1);
        er(96);
        chk("R12 no verification", sv, 1'b0);

        // Correct code without ritual
        go(0);
        present(0, NONE, NONE);
        go(97);
        go(104);
        chk("R2 no sv without ritual", sv, 1'b0);

        // Interrupted code then ritual
        go(0);
        present(0, NONE, 8'd8);
        go(96);
        go(97);
        wr(97);
        er(97);
        chk("R11 interrupted code sv", sv, 1'b0);
        chk("R11 interrupted code status", status_bit, 1'b1);

        // Successful verification on bit 98
        go(0);
        present(0, NONE, NONE);
        go(96); go(97); go(98);
        wr(98);
        chk("R3 status after write", status_bit, 1'b0);
        er(98);
        chk("R3 status after good erase", status_bit, 1'b0);
        chk("R2 sv set", sv, 1'b1);
        chk("R4 wipe pulse", att_wipe, 1'b1);
        go(98);
        chk("R4 wipe one cycle", att_wipe, 1'b0);
        chk("R4 counter refilled", mem[98], 1'b1);
        go(0);
        chk("R6 sv survives addr 0", sv, 1'b1);

        // R9 counted key-2 erase
        ec_fuse = 1'b1;
        go(0);
        present(2, NONE, NONE);
        chk("R9 e2 not set by match alone", e2, 1'b0);
        go(1280);
        wr(1280);
        chk("R9 status after counter write", status_bit, 1'b0);
        er(1280);
        chk("R9 e2 set after ritual", e2, 1'b1);
        chk("R9 no wipe from counter", att_wipe, 1'b0);
        go(0);
        present(2, 8'd3, NONE);
        go(1281);
        wr(1281);
        er(1281);
        chk("R9 wrong key e2", e2, 1'b0);
        chk("R9 wrong key status", status_bit, 1'b1);
        ec_fuse = 1'b0;

        // R5 lock after eight failures
        rst = 1'b1;
        cyc(); cyc();
        rst = 1'b0;
        go(0);
        chk("R1 sv cleared by power-on reset", sv, 1'b0);
        for (int k = 0; k < 7; k++) fail_try(k);
        go(103);
        chk("R5 not locked after seven", locked, 1'b0);
        fail_try(7);
        go(103);
        chk("R5 locked after eight", locked, 1'b1);
        go(0);
        present(0, NONE, NONE);
        for (int a = 96; a <= 103; a++) go(a);
        wr(100);
        er(100);
        chk("R5 sv blocked when locked", sv, 1'b0);
        chk("R5 lock sticky", locked, 1'b1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule